// File: doc/BRIEF.md
# Timer pin function selector with edge-event status

This block owns the single I/O pin of a general-purpose timer channel. A mode register picks what the pin is used for: idle, capture input, compare output, PWM output, or plain GPIO. In GPIO mode the pin level is set by a two-bit drive field held in the mode register itself. There is no separate data register. An open-drain flag turns a driven high into a released pin.

In capture mode the pin is an input only. It is sampled through a two-flop synchronizer, and rising and falling transitions are turned into sticky event flags in a status register. Software clears these flags by writing ones to them. The interrupt line is the OR of the pending flags, gated by an enable bit. The current synchronized pin level can always be read from the status register. Compare and PWM waveforms and capture timestamps are not part of this block: in those modes the pin is simply released.

The register port has one select bit: 0 picks the mode register and 1 picks the status register. Writes take effect at the next clock edge. Reads are combinational.

Pin function (the decoded select) states: `PF_OFF` (select 0 and the unused codes 5 to 7), `PF_CAPTURE` (1), `PF_COMPARE` (2), `PF_PWM` (3), `PF_GPIO` (4). Transitions between them happen only on a write to the mode register, from any state to the state named by the written select field. Reset enters `PF_OFF`.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset the mode and status registers read 0, `pin_oe` is 0 and `irq` is 0.
- R2: Mode register fields are select [2:0], drive [5:4], interrupt enable [8], open-drain [9] and edge type [17:16]. All other bits read back as 0, so writing all ones reads back 0x00030337.
- R3: In GPIO mode (select 4), drive 10 gives `pin_oe`=1 and `pin_out`=0. Drive 11 gives `pin_oe`=1 and `pin_out`=1. Drive 00 or 01 gives `pin_oe`=0.
- R4: In GPIO mode with open-drain set, drive 11 gives `pin_oe`=0 and `pin_out`=0, while drive 10 still drives low.
- R5: In every select value other than 4, `pin_oe`=0 and `pin_out`=0, whatever the drive and open-drain bits hold.
- R6: Status bit 8 reads the synchronized pin level in every mode. A pin change appears there after the second rising clock edge.
- R7: In capture mode, status bit 0 is set on a rising transition when edge type bit 0 is 1, and on a falling transition when edge type bit 1 is 1. Edge type 00 never sets it.
- R8: In capture mode, status bit 1 is set on any rising transition and status bit 2 on any falling transition, independent of edge type. No status bit is ever set outside capture mode.
- R9: Status bit 3 (overrun) is set when a selected transition occurs while status bit 0 is already set.
- R10: Writing to the status register clears each bit [3:0] written as 1 and leaves bits written as 0 unchanged. A write to the mode register does not touch the status bits.
- R11: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R12: `irq` equals the OR of status bits [3:0] ANDed with mode bit 8. Events are recorded in the status register while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = mode register, 1 = status register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| pin_in | input | 1 | Asynchronous pin input level |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same edge: a status bit being set by a synchronized transition, and that same bit being cleared by a status write. The bench raises the pin, counts the two synchronizer edges, and holds a write of all ones across the exact edge on which the event registers. The result must show the event bits still set while an untouched bit is cleared, as R11 requires. The overrun flag is taken through the same collision, since its setting depends on the flag being cleared.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

    localparam int DATA_W    = 32;
    localparam int EVT_W     = 4;
    localparam int LEVEL_BIT = 8;
    localparam logic [DATA_W-1:0] MODE_MASK = 32'h0003_0337;

    typedef enum logic [2:0] {
        PF_OFF     = 3'd0,
        PF_CAPTURE = 3'd1,
        PF_COMPARE = 3'd2,
        PF_PWM     = 3'd3,
        PF_GPIO    = 3'd4
    } pin_func_e;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic       od;
        logic       ien;
        logic [1:0] drive;
        logic [2:0] msel;
    } mode_t;

    function automatic pin_func_e decode_func(input logic [2:0] sel);
        pin_func_e f;
        unique case (sel)
            3'd1:    f = PF_CAPTURE;
            3'd2:    f = PF_COMPARE;
            3'd3:    f = PF_PWM;
            3'd4:    f = PF_GPIO;
            default: f = PF_OFF;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/tpin_regs.sv
module tpin_regs
    import tpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              level,
    output mode_t             mode,
    output pin_func_e         func,
    output logic [EVT_W-1:0]  status,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mode_q;
    logic [EVT_W-1:0]  status_q;
    logic [EVT_W-1:0]  set_vec;
    logic [EVT_W-1:0]  clr_vec;
    logic              hit;
    logic [DATA_W-1:0] stat_word;

    assign mode = mode_t'({mode_q[17:16], mode_q[9], mode_q[8],
                           mode_q[5:4], mode_q[2:0]});
    assign func = decode_func(mode.msel);

    always_comb begin
        set_vec = '0;
        hit     = 1'b0;
        unique case (func)
            PF_CAPTURE: begin
                hit        = (rise & mode.edge_sel[0]) | (fall & mode.edge_sel[1]);
                set_vec[0] = hit;
                set_vec[1] = rise;
                set_vec[2] = fall;
                set_vec[3] = hit & status_q[0];
            end
            default: ;
        endcase
    end

    assign clr_vec = (wr_en && reg_sel) ? wdata[EVT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_en && !reg_sel)
                mode_q <= wdata & MODE_MASK;
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        stat_word            = '0;
        stat_word[EVT_W-1:0] = status_q;
        stat_word[LEVEL_BIT] = level;
    end

    assign rdata  = reg_sel ? stat_word : mode_q;
    assign status = status_q;

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && wdata[1] && !set_vec[1]) |=> !status_q[1]);

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[0] |=> status_q[0]);

    assert_rise_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (func == PF_CAPTURE && rise) |=> status_q[1]);

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import tpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_func_e func,
    input  mode_t     mode,
    output logic      pin_out,
    output logic      pin_oe
);
    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        unique case (func)
            PF_GPIO: begin
                if (mode.drive == 2'b10) begin
                    pin_oe = 1'b1;
                end else if (mode.drive == 2'b11) begin
                    pin_oe  = ~mode.od;
                    pin_out = ~mode.od;
                end
            end
            default: ;
        endcase
    end

    assert_tristate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (func != PF_GPIO) |-> (!pin_oe && !pin_out));

endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
    import tpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);
    logic             level, rise, fall;
    mode_t            mode;
    pin_func_e        func;
    logic [EVT_W-1:0] status;

    tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .level(level), .rise(rise), .fall(fall)
    );

    tpin_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rise(rise), .fall(fall), .level(level),
        .mode(mode), .func(func), .status(status), .rdata(rdata)
    );

    tpin_drive u_drive (
        .clk(clk), .rst_n(rst_n), .func(func), .mode(mode),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign irq = mode.ien & (|status);

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == rdata) && !mode.ien |-> !irq);

endmodule

// File: tb/tpin_ctrl_tb.sv
module tpin_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;
    int          checks = 0;
    int          failures = 0;
    logic        done = 1'b0;

    tpin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1 v = rdata;
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [3:0]  s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, v); chk("R1 mode", v, 32'h0);
        rd(1'b1, v); chk("R1 status", v, 32'h0);
        chk("R1 oe", {31'b0, pin_oe}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 mask
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R2 mask", v, 32'h0003_0337);

        // R3 R4 R5 drive sweep
        for (int ms = 0; ms < 8; ms++)
            for (int dr = 0; dr < 4; dr++)
                for (int od = 0; od < 2; od++) begin
                    logic g, eoe, eout;
                    wr(1'b0, 32'(ms) | (32'(dr) << 4) | (32'(od) << 9));
                    g    = (ms == 4);
                    eoe  = g && (dr[1] == 1'b1) && !(dr[0] && od[0]);
                    eout = g && (dr == 3) && !od[0];
                    #1;
                    chk(g ? (od[0] ? "R4 oe" : "R3 oe") : "R5 oe", {31'b0, pin_oe}, {31'b0, eoe});
                    chk(g ? (od[0] ? "R4 out" : "R3 out") : "R5 out", {31'b0, pin_out}, {31'b0, eout});
                end

        // R6 level latency
        wr(1'b0, 32'h0);
        @(negedge clk);
        pin_in = 1'b1; reg_sel = 1'b1;
        @(negedge clk); #1 chk("R6 level after 1 edge", {31'b0, rdata[8]}, 32'h0);
        @(negedge clk); #1 chk("R6 level after 2 edges", {31'b0, rdata[8]}, 32'h1);
        pin_to(1'b0);

        // R7 R8 R9 R12 event sweep
        for (int ms = 0; ms < 8; ms++)
            for (int et = 0; et < 4; et++)
                for (int ie = 0; ie < 2; ie++) begin
                    logic cap, hit;
                    logic [1:0] etv;
                    etv = et[1:0];
                    cap = (ms == 1);
                    wr(1'b0, 32'(ms) | (32'(ie) << 8) | (32'(et) << 16));
                    wr(1'b1, 32'hF);
                    pin_to(1'b1);
                    s = {2'b00, cap, cap & etv[0]};
                    rd(1'b1, v);
                    chk(cap ? "R7 rise status" : "R8 no event outside capture", v, {23'b0, 1'b1, 4'b0, s});
                    chk("R12 irq after rise", {31'b0, irq}, {31'b0, ie[0] & (|s)});
                    pin_to(1'b0);
                    hit = cap & etv[1];
                    s = s | {hit & s[0], cap, 1'b0, hit};
                    rd(1'b1, v);
                    chk(cap ? "R9 fall status" : "R8 no event outside capture", v, {28'b0, s});
                    chk("R12 irq after fall", {31'b0, irq}, {31'b0, ie[0] & (|s)});
                end

        // R10 write-one-to-clear
        wr(1'b0, 32'h0003_0001);
        wr(1'b1, 32'hF);
        pin_to(1'b1);
        pin_to(1'b0);
        rd(1'b1, v); chk("R10 preset", v, 32'hF);
        wr(1'b1, 32'h5);
        rd(1'b1, v); chk("R10 partial clear", v, 32'hA);
        wr(1'b1, 32'h0);
        rd(1'b1, v); chk("R10 zero write", v, 32'hA);
        wr(1'b0, 32'h0003_0009);
        rd(1'b1, v); chk("R10 mode write leaves status", v, 32'hA);

        // R11 collision: event edge and clear write on the same edge
        wr(1'b0, 32'h0003_0101);
        wr(1'b1, 32'hF);
        pin_to(1'b1);
        rd(1'b1, v); chk("R11 pre", v, 32'h0000_0103);
        @(negedge clk);
        pin_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 1'b1; wdata = 32'hF;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        rd(1'b1, v); chk("R11 event wins", v, 32'h0000_000D);
        chk("R11 irq", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule